// File: doc/BRIEF.md
# Load-Use Interlock and Pipeline Freeze Controller

This block decides, every cycle, which pipeline registers of a five-stage in-order integer pipeline may latch. The stages are fetch, decode, execute, memory and writeback. It looks at the source register numbers of the instruction in decode and at the destination, write flag and load flag of the instruction in execute. It also takes a memory-miss request. From these it drives one enable per pipeline register, a commit enable for writeback, and a bubble control that turns the decode-to-execute register into a no-op slot.

The block has two stall styles. A load-use hazard calls for an elastic stall. A value loaded by the instruction in execute is only ready after the memory stage, so a consumer directly behind it holds for one cycle while a bubble moves ahead. A memory miss calls for a freeze. Every register holds and writeback is suppressed for as long as the miss stays asserted. The block is purely combinational. Once a freeze ends it re-evaluates the hazard from whatever decode and execute then hold.

Top module: `pipe_interlock`

## Requirements
- R1: With no memory miss and no load-use hazard, pcEn, ifIdEn, idExEn, exMemEn, memWbEn and wbCommitEn are all 1 and idExBubble is 0.
- R2: A load-use hazard exists when the execute instruction has both exIsLoad=1 and exRegWrite=1, exRd is nonzero, and exRd equals idRs. Without a miss it drives pcEn=0, ifIdEn=0 and idExBubble=1, while idExEn, exMemEn, memWbEn and wbCommitEn stay 1.
- R3: A match between exRd and idRt counts as a hazard only when idUsesRt=1. With idUsesRt=0 an rt match alone leaves the outputs as in R1.
- R4: A load whose destination is register 0 never causes a stall, even when idRs or idRt (with idUsesRt=1) is 0.
- R5: A matching destination does not stall when exIsLoad=0, or when exIsLoad=1 with exRegWrite=0.
- R6: While memMiss=1, all six enables are 0 and idExBubble is 0.
- R7: When memMiss=1 and a load-use hazard occur together, the freeze outputs of R6 apply. In the first cycle after memMiss falls with the hazard still present, the load-use outputs of R2 apply.
- R8: The bubble is only ever raised together with idExEn=1, so that the no-op control word is actually loaded into the decode-to-execute register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs | input | 5 | First source register of the decode instruction |
| idRt | input | 5 | Second source register of the decode instruction |
| idUsesRt | input | 1 | Decode instruction reads idRt as a source |
| exRd | input | 5 | Destination register of the execute instruction |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| memMiss | input | 1 | Memory miss, requests a global freeze |
| pcEn | output | 1 | Program counter update enable |
| ifIdEn | output | 1 | Fetch-to-decode register enable |
| idExEn | output | 1 | Decode-to-execute register enable |
| idExBubble | output | 1 | Load a no-op control word into decode-to-execute |
| exMemEn | output | 1 | Execute-to-memory register enable |
| memWbEn | output | 1 | Memory-to-writeback register enable |
| wbCommitEn | output | 1 | Allows writeback to commit results |

## Verification
The freeze and the load-use interlock can be requested in the same cycle. The bench provokes this by holding a hazardous decode/execute pair (on rs, and separately on rt) while memMiss is raised. It then expects the all-zero freeze pattern with no bubble. It keeps the same pair in place, drops memMiss, and judges the next cycle against the elastic stall pattern. A further step clears the hazard while the miss is still high, and the bench expects the freeze to persist alone.

// File: rtl/pipe_interlock_pkg.sv
package pipe_interlock_pkg;

  // per-stage strobes from the control to the top
  typedef struct packed {
    logic pcEn;
    logic ifIdEn;
    logic idExEn;
    logic idExBubble;
    logic exMemEn;
    logic memWbEn;
    logic wbCommitEn;
  } stageStrobes_t;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_ELASTIC = 2'd1,
    MODE_FREEZE = 2'd2
  } stallMode_t;

endpackage

// File: rtl/pipe_interlock_match.sv
module pipe_interlock_match #(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_SRC    = 2
) (
  input  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] srcReg,
  input  logic [NUM_SRC-1:0]                 srcValid,
  input  logic [REG_ADDR_W-1:0]              dstReg,
  input  logic                               dstLoadWrite,
  output logic [NUM_SRC-1:0]                 srcHit
);
  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic dstLive;
  assign dstLive = dstLoadWrite && (dstReg != ZERO_REG);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign srcHit[g] = dstLive && srcValid[g] && (srcReg[g] == dstReg);
  end

  always_comb begin
    AST_ZERO_DST_NO_HIT: assert (!(dstReg == ZERO_REG && |srcHit)) else $error("hit on register 0"); // R4
    AST_NO_LOAD_NO_HIT: assert (dstLoadWrite || srcHit == '0) else $error("hit without load"); // R5
  end

endmodule

// File: rtl/pipe_interlock_ctl.sv
module pipe_interlock_ctl
  import pipe_interlock_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] srcHit,
  input  logic               memMiss,
  output stallMode_t         mode,
  output stageStrobes_t      strobes
);

  always_comb begin
    if (memMiss)        mode = MODE_FREEZE;
    else if (|srcHit)   mode = MODE_ELASTIC;
    else                mode = MODE_RUN;
  end

  always_comb begin
    strobes = '{pcEn: 1'b1, ifIdEn: 1'b1, idExEn: 1'b1, idExBubble: 1'b0,
                exMemEn: 1'b1, memWbEn: 1'b1, wbCommitEn: 1'b1};
    unique case (mode)
      MODE_ELASTIC: begin
        strobes.pcEn       = 1'b0;
        strobes.ifIdEn     = 1'b0;
        strobes.idExBubble = 1'b1;
      end
      MODE_FREEZE: begin
        strobes = '0;
      end
      default: ;
    endcase
  end

  always_comb begin
    AST_FREEZE_HOLDS_ALL: assert (!memMiss || strobes == '0) else $error("freeze leak"); // R6
    AST_FREEZE_WINS: assert (!(memMiss && strobes.idExBubble)) else $error("bubble in freeze"); // R7
    AST_BUBBLE_LOADS: assert (!strobes.idExBubble || strobes.idExEn) else $error("bubble not loaded"); // R8
    AST_BUBBLE_HOLDS_FRONT: assert (!strobes.idExBubble || (!strobes.pcEn && !strobes.ifIdEn && strobes.exMemEn)) else $error("elastic shape"); // R2
  end

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_interlock_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] idRs,
  input  logic [REG_ADDR_W-1:0] idRt,
  input  logic                  idUsesRt,
  input  logic [REG_ADDR_W-1:0] exRd,
  input  logic                  exRegWrite,
  input  logic                  exIsLoad,
  input  logic                  memMiss,
  output logic                  pcEn,
  output logic                  ifIdEn,
  output logic                  idExEn,
  output logic                  idExBubble,
  output logic                  exMemEn,
  output logic                  memWbEn,
  output logic                  wbCommitEn
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] srcReg;
  logic [NUM_SRC-1:0]                 srcValid;
  logic [NUM_SRC-1:0]                 srcHit;
  stallMode_t                         mode;
  stageStrobes_t                      strobes;

  assign srcReg   = {idRt, idRs};
  assign srcValid = {idUsesRt, 1'b1};

  pipe_interlock_match #(.REG_ADDR_W(REG_ADDR_W), .NUM_SRC(NUM_SRC)) u_match (
    .srcReg(srcReg),
    .srcValid(srcValid),
    .dstReg(exRd),
    .dstLoadWrite(exIsLoad && exRegWrite),
    .srcHit(srcHit)
  );

  pipe_interlock_ctl #(.NUM_SRC(NUM_SRC)) u_ctl (
    .srcHit(srcHit),
    .memMiss(memMiss),
    .mode(mode),
    .strobes(strobes)
  );

  assign pcEn       = strobes.pcEn;
  assign ifIdEn     = strobes.ifIdEn;
  assign idExEn     = strobes.idExEn;
  assign idExBubble = strobes.idExBubble;
  assign exMemEn    = strobes.exMemEn;
  assign memWbEn    = strobes.memWbEn;
  assign wbCommitEn = strobes.wbCommitEn;

  always_comb begin
    AST_RUN_MODE_OPEN: assert (mode != MODE_RUN || (pcEn && ifIdEn && !idExBubble && wbCommitEn)) else $error("run closed"); // R1
  end

endmodule

// File: tb/pipe_interlock_bench.sv
module pipe_interlock_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0] idRs, idRt, exRd;
  logic idUsesRt, exRegWrite, exIsLoad, memMiss;
  logic pcEn, ifIdEn, idExEn, idExBubble, exMemEn, memWbEn, wbCommitEn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // {pcEn, ifIdEn, idExEn, idExBubble, exMemEn, memWbEn, wbCommitEn}
  localparam logic [6:0] RUN    = 7'b1110111;
  localparam logic [6:0] STALL  = 7'b0011111;
  localparam logic [6:0] FREEZE = 7'b0000000;

  pipe_interlock u_pipe_interlock (
    .idRs(idRs), .idRt(idRt), .idUsesRt(idUsesRt), .exRd(exRd),
    .exRegWrite(exRegWrite), .exIsLoad(exIsLoad), .memMiss(memMiss),
    .pcEn(pcEn), .ifIdEn(ifIdEn), .idExEn(idExEn), .idExBubble(idExBubble),
    .exMemEn(exMemEn), .memWbEn(memWbEn), .wbCommitEn(wbCommitEn)
  );

  task automatic apply(input logic [4:0] rs, input logic [4:0] rt, input logic useRt,
                       input logic [4:0] rd, input logic wr, input logic ld, input logic miss);
    @(negedge clk);
    idRs = rs; idRt = rt; idUsesRt = useRt; exRd = rd;
    exRegWrite = wr; exIsLoad = ld; memMiss = miss;
    #2;
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] got;
    got = {pcEn, ifIdEn, idExEn, idExBubble, exMemEn, memWbEn, wbCommitEn};
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic t_run;
    apply(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0); check("R1 idle", RUN);
    apply(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 1'b1, 1'b0); check("R1 load no match", RUN);
    apply(5'd9, 5'd9, 1'b1, 5'd9, 1'b1, 1'b0, 1'b0); check("R1 alu match", RUN);
  endtask

  task automatic t_rs;
    apply(5'd5, 5'd1, 1'b0, 5'd5, 1'b1, 1'b1, 1'b0); check("R2 rs match", STALL);
    apply(5'd31, 5'd2, 1'b1, 5'd31, 1'b1, 1'b1, 1'b0); check("R2 rs match r31", STALL);
    apply(5'd31, 5'd2, 1'b1, 5'd6, 1'b1, 1'b1, 1'b0); check("R2 after bubble", RUN);
  endtask

  task automatic t_rt;
    apply(5'd1, 5'd12, 1'b1, 5'd12, 1'b1, 1'b1, 1'b0); check("R3 rt used", STALL);
    apply(5'd1, 5'd12, 1'b0, 5'd12, 1'b1, 1'b1, 1'b0); check("R3 rt unused", RUN);
  endtask

  task automatic t_zero;
    apply(5'd0, 5'd3, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0); check("R4 rs zero", RUN);
    apply(5'd2, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 1'b0); check("R4 rt zero", RUN);
  endtask

  task automatic t_noload;
    apply(5'd8, 5'd8, 1'b1, 5'd8, 1'b1, 1'b0, 1'b0); check("R5 not load", RUN);
    apply(5'd8, 5'd8, 1'b1, 5'd8, 1'b0, 1'b1, 1'b0); check("R5 no write", RUN);
  endtask

  task automatic t_freeze;
    apply(5'd1, 5'd2, 1'b1, 5'd3, 1'b1, 1'b0, 1'b1); check("R6 freeze", FREEZE);
    apply(5'd1, 5'd2, 1'b1, 5'd3, 1'b1, 1'b0, 1'b1); check("R6 freeze held", FREEZE);
    apply(5'd1, 5'd2, 1'b1, 5'd3, 1'b1, 1'b0, 1'b0); check("R6 release", RUN);
  endtask

  task automatic t_both;
    apply(5'd10, 5'd2, 1'b0, 5'd10, 1'b1, 1'b1, 1'b1); check("R7 both rs", FREEZE);
    apply(5'd10, 5'd2, 1'b0, 5'd10, 1'b1, 1'b1, 1'b0); check("R7 after freeze", STALL);
    apply(5'd4, 5'd17, 1'b1, 5'd17, 1'b1, 1'b1, 1'b1); check("R7 both rt", FREEZE);
    apply(5'd4, 5'd17, 1'b1, 5'd3, 1'b1, 1'b1, 1'b1); check("R7 hazard gone", FREEZE);
    apply(5'd4, 5'd17, 1'b1, 5'd17, 1'b1, 1'b1, 1'b0); check("R7 rt after", STALL);
  endtask

  task automatic t_bubbleLoad;
    apply(5'd6, 5'd0, 1'b0, 5'd6, 1'b1, 1'b1, 1'b0);
    nChecks++;
    if (!(idExBubble === 1'b1 && idExEn === 1'b1)) begin
      nFails++;
      $display("FAIL R8: bubble=%b idExEn=%b expected 1 1", idExBubble, idExEn);
    end
  endtask

  initial begin
    idRs = '0; idRt = '0; idUsesRt = 1'b0; exRd = '0;
    exRegWrite = 1'b0; exIsLoad = 1'b0; memMiss = 1'b0;
    #3;
    check("R1 reset state", RUN);
    t_run();
    t_rs();
    t_rt();
    t_zero();
    t_noload();
    t_freeze();
    t_both();
    t_bubbleLoad();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule